// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host and an external asynchronous static RAM of 512K 16-bit words. The host presents one request at a time over a valid/ready handshake. A request carries a direction flag, a 19-bit word address, 16 bits of write data and a two-bit lane mask. The controller drives the memory pins: an active-low select and an active-high select, a read strobe, a write strobe, one active-low enable for each byte lane, a 19-bit address, and a split data bus with an output enable for the controller's own drivers. On a read it returns the word with a one-clock valid pulse.

Every analogue time the memory needs becomes a whole number of clocks. Each time is divided by the `CLK_NS` parameter and rounded up. `FAST_GRADE` picks the set of times: 1 gives 40 ns cycle, 25 ns read-strobe access, 30 ns write pulse, 20 ns data setup and 20 ns release. 0 gives 55, 30, 40, 25 and 25 ns. Between transactions the memory is left deselected. After a read, the controller keeps its drivers off long enough for the memory to stop driving the bus.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, and in every idle cycle, the active-low select is high and the active-high select is low. The read strobe, the write strobe and both lane enables are high, the data driver is off, and rd_valid is low.
- R2: Clock counts are ceil(t / CLK_NS). These counts are the cycle length C, the read-strobe access O, the write pulse W, the data setup D and the release time T. The write phase lasts L = max(C, W) cycles.
- R3: After a read is accepted, the memory is selected for exactly C cycles, starting the next cycle. mem_addr holds the request address and the write strobe stays high. The read strobe is low only in the last O of those cycles.
- R4: Read data is sampled from mem_dq_i at the clock edge that ends the last read cycle. rd_valid is high for exactly the following cycle, with that data on rd_data.
- R5: After a write is accepted, the memory is selected for L cycles with the read strobe high. The write strobe is low only in the last W cycles. The driver is on only in the last D cycles, and it then carries the request's write data.
- R6: The controller's data driver is never on while the write strobe is high. The driver and the write strobe release at the same edge.
- R7: After a read ends, req_ready is low for write requests during the next T cycles. Read requests are still accepted during those cycles.
- R8: req_ready is high only when no transaction is in progress. At least one deselected cycle separates two transactions.
- R9: Mask bit 0 enables bits 7:0 and bit 1 enables bits 15:8. A lane's enable is low only while a transaction that has its mask bit set is in progress. A lane with a clear mask bit is returned as zero on a read and is not written.
- R10: The read strobe and the write strobe are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = low byte |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_lo_n | output | 1 | Active-low low-byte enable |
| mem_hi_n | output | 1 | Active-low high-byte enable |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The bench builds the block with `CLK_NS = 8` and `FAST_GRADE = 1`. This gives C = 5, O = 4, W = 4, D = 3 and T = 3. Under these values the read strobe, the write strobe and the driver each change on a different cycle inside a transaction, so an off-by-one on any one of them stands out. The three-cycle release window is long enough to see a write stall right after a read while a read passes through. A bench memory holds the data, and some of its cells are at the highest address. That memory puts filler bytes on lanes that are not enabled, so the zeroing of disabled lanes is observable.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW         = 19,
  parameter int DW         = 16,
  parameter int CLK_NS     = 10,
  parameter int FAST_GRADE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lo_n,
  output logic          mem_hi_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int HB     = DW / 2;
  localparam int T_CYC  = FAST_GRADE ? 40 : 55;
  localparam int T_OE   = FAST_GRADE ? 25 : 30;
  localparam int T_WP   = FAST_GRADE ? 30 : 40;
  localparam int T_DS   = FAST_GRADE ? 20 : 25;
  localparam int T_HZ   = FAST_GRADE ? 20 : 25;
  localparam int N_CYC  = (T_CYC + CLK_NS - 1) / CLK_NS;
  localparam int N_OE   = (T_OE  + CLK_NS - 1) / CLK_NS;
  localparam int N_WP   = (T_WP  + CLK_NS - 1) / CLK_NS;
  localparam int N_DS   = (T_DS  + CLK_NS - 1) / CLK_NS;
  localparam int N_TA   = (T_HZ  + CLK_NS - 1) / CLK_NS;
  localparam int N_WLEN = (N_CYC > N_WP) ? N_CYC : N_WP;
  localparam int CW     = $clog2(N_WLEN + 1);
  localparam int TW     = $clog2(N_TA + 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t           st_q, st_d;
  logic [CW-1:0] idx_q, idx_d;
  logic [TW-1:0] ta_q, ta_d;
  logic [1:0]    be_q, be_d;
  logic [DW-1:0] wd_q;
  logic          accept, rd_last, wr_last, act_d;

  assign req_ready = (st_q == S_IDLE) && (!req_write || ta_q == '0);
  assign accept    = req_valid && req_ready;
  assign rd_last   = (st_q == S_RD) && (idx_q == CW'(N_CYC - 1));
  assign wr_last   = (st_q == S_WR) && (idx_q == CW'(N_WLEN - 1));
  assign be_d      = accept ? req_be : be_q;
  assign act_d     = (st_d != S_IDLE);
  assign mem_dq_o  = wd_q;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    ta_d  = (ta_q != '0) ? ta_q - TW'(1) : ta_q;
    case (st_q)
      S_IDLE: if (accept) begin
        st_d  = req_write ? S_WR : S_RD;
        idx_d = '0;
      end
      S_RD: if (rd_last) begin
        st_d = S_IDLE;
        ta_d = TW'(N_TA);
      end else idx_d = idx_q + CW'(1);
      S_WR: if (wr_last) st_d = S_IDLE;
            else idx_d = idx_q + CW'(1);
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      idx_q     <= '0;
      ta_q      <= '0;
      be_q      <= '0;
      wd_q      <= '0;
      mem_addr  <= '0;
      mem_sel_n <= 1'b1;
      mem_sel   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_lo_n  <= 1'b1;
      mem_hi_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      st_q      <= st_d;
      idx_q     <= idx_d;
      ta_q      <= ta_d;
      be_q      <= be_d;
      if (accept) begin
        mem_addr <= req_addr;
        wd_q     <= req_wdata;
      end
      mem_sel_n <= !act_d;
      mem_sel   <= act_d;
      mem_oe_n  <= !((st_d == S_RD) && (int'(idx_d) + N_OE >= N_CYC));
      mem_we_n  <= !((st_d == S_WR) && (int'(idx_d) + N_WP >= N_WLEN));
      mem_dq_oe <=   (st_d == S_WR) && (int'(idx_d) + N_DS >= N_WLEN);
      mem_lo_n  <= !(act_d && be_d[0]);
      mem_hi_n  <= !(act_d && be_d[1]);
      rd_valid  <= rd_last;
      if (rd_last)
        rd_data <= {be_q[1] ? mem_dq_i[DW-1:HB] : {HB{1'b0}},
                    be_q[0] ? mem_dq_i[HB-1:0]  : {HB{1'b0}}};
    end
  end

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  assert_drv_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (ta_q == '0));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

  assert_rv_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel));

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;
  localparam int AW = 19;
  localparam int DW = 16;
  localparam int CK = 8;
  localparam int E_CYC  = (40 + CK - 1) / CK;
  localparam int E_OE   = (25 + CK - 1) / CK;
  localparam int E_WP   = (30 + CK - 1) / CK;
  localparam int E_DS   = (20 + CK - 1) / CK;
  localparam int E_TA   = (20 + CK - 1) / CK;
  localparam int E_WLEN = (E_CYC > E_WP) ? E_CYC : E_WP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rd_valid, mem_sel_n, mem_sel, mem_oe_n, mem_we_n;
  logic mem_lo_n, mem_hi_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;

  always #4 clk = ~clk;

  sram_lane_ctrl #(.AW(AW), .DW(DW), .CLK_NS(CK), .FAST_GRADE(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lo_n(mem_lo_n),
    .mem_hi_n(mem_hi_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i));

  logic [15:0] mem_arr [0:255];
  logic [15:0] gold    [0:255];
  logic        rd_drive;
  assign rd_drive = !mem_sel_n && mem_sel && !mem_oe_n && mem_we_n;
  assign mem_dq_i = {(rd_drive && !mem_hi_n) ? mem_arr[mem_addr[7:0]][15:8] : 8'hA5,
                     (rd_drive && !mem_lo_n) ? mem_arr[mem_addr[7:0]][7:0]  : 8'h5A};

  always @(negedge clk)
    if (!mem_sel_n && mem_sel && !mem_we_n && mem_dq_oe) begin
      if (!mem_lo_n) mem_arr[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
      if (!mem_hi_n) mem_arr[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
    end

  int n_cmp = 0, n_bad = 0;
  int m_kind = 0, m_left = 0, m_ta = 0;
  logic m_rv = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [1:0] m_be = '0;
  logic [15:0] m_wd = '0, m_rdat = '0;

  function automatic logic exp_ready();
    return (m_kind == 0) && (!req_write || m_ta == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_kind = 0; m_left = 0; m_ta = 0; m_rv = 1'b0;
    end else begin
      logic go;
      go = req_valid && exp_ready();
      m_rv = 1'b0;
      if (m_ta > 0) m_ta = m_ta - 1;
      if (m_kind == 0) begin
        if (go) begin
          m_kind = req_write ? 2 : 1;
          m_left = req_write ? E_WLEN : E_CYC;
          m_addr = req_addr; m_be = req_be; m_wd = req_wdata;
          if (req_write) begin
            if (req_be[0]) gold[req_addr[7:0]][7:0]  = req_wdata[7:0];
            if (req_be[1]) gold[req_addr[7:0]][15:8] = req_wdata[15:8];
          end
        end
      end else if (m_left == 1) begin
        if (m_kind == 1) begin
          m_rv = 1'b1;
          m_ta = E_TA;
          m_rdat = {m_be[1] ? gold[m_addr[7:0]][15:8] : 8'h00,
                    m_be[0] ? gold[m_addr[7:0]][7:0]  : 8'h00};
        end
        m_kind = 0;
      end else m_left = m_left - 1;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] a, input logic [31:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, a, e, $time);
    end
  endtask

  always @(negedge clk) begin
    logic act;
    string ct, lt;
    act = (m_kind != 0);
    ct  = (m_kind == 0) ? "R1" : ((m_kind == 1) ? "R3" : "R5");
    lt  = (act && m_be == 2'b00) ? "R9" : ct;
    chk(ct, "sel_n", mem_sel_n, !act);
    chk(ct, "sel", mem_sel, act);
    chk("R2", "oe_n", mem_oe_n, !(m_kind == 1 && m_left <= E_OE));
    chk("R2", "we_n", mem_we_n, !(m_kind == 2 && m_left <= E_WP));
    chk("R5", "dq_oe", mem_dq_oe, (m_kind == 2 && m_left <= E_DS));
    chk(lt, "lo_n", mem_lo_n, !(act && m_be[0]));
    chk(lt, "hi_n", mem_hi_n, !(act && m_be[1]));
    if (act) chk(ct, "addr", mem_addr, m_addr);
    if (m_kind == 2 && m_left <= E_DS) chk("R5", "dq_o", mem_dq_o, m_wd);
    chk("R6", "drv_no_we", mem_dq_oe && mem_we_n, 0);
    chk("R10", "strobe_overlap", !mem_we_n && !mem_oe_n, 0);
    chk((m_ta != 0) ? "R7" : "R8", "ready", req_ready, exp_ready());
    chk("R4", "rd_valid", rd_valid, m_rv);
    if (m_rv) chk((m_be == 2'b00) ? "R9" : "R4", "rd_data", rd_data, m_rdat);
  end

  task automatic req(input logic wr, input logic [AW-1:0] a,
                     input logic [15:0] d, input logic [1:0] be);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    #1;
    while (!req_ready) begin @(negedge clk); #2; end
    @(negedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_arr[i] = 16'(i * 257) ^ 16'hC33C;
      gold[i]    = 16'(i * 257) ^ 16'hC33C;
    end
    repeat (5) @(negedge clk);
    #2 rst_n = 1'b1;
    idle(3);
    req(1'b1, 19'h00010, 16'h1234, 2'b11);
    req(1'b0, 19'h00010, 16'h0000, 2'b11);
    req(1'b1, 19'h00011, 16'hBEEF, 2'b01);
    req(1'b0, 19'h00011, 16'h0000, 2'b11);
    req(1'b0, 19'h00010, 16'h0000, 2'b01);
    req(1'b0, 19'h00010, 16'h0000, 2'b10);
    req(1'b0, 19'h00010, 16'h0000, 2'b00);
    req(1'b1, 19'h00020, 16'hFFFF, 2'b00);
    req(1'b0, 19'h00020, 16'h0000, 2'b11);
    req(1'b1, 19'h7FFFF, 16'hA1B2, 2'b10);
    idle(6);
    req(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
    req(1'b0, 19'h00000, 16'h0000, 2'b11);
    req(1'b1, 19'h00000, 16'h5566, 2'b11);
    req(1'b0, 19'h00000, 16'h0000, 2'b11);
    idle(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule